// File: doc/BRIEF.md
# DMA Page-Table Address Translator

This block turns 32-bit addresses issued by DMA devices into physical memory addresses. It splits each incoming address into a page number and a 12-bit offset within a 4096-byte page. It then looks that page number up in a single-level table that lives in system memory. Each table slot is 8 bytes wide. The first 32-bit word of a slot holds the physical frame, and the second word is not used. Every in-range lookup fetches its slot through a single-outstanding memory read port. No translation is kept between lookups.

Software sets up two registers through a narrow write port: the table origin and the table extent. The extent is given in bytes. A lookup is answered with a one-cycle response pulse. The response carries either a translated address with read/write permission, or a fault with no permission. A fault occurs when the page number lies past the table extent or when the table read returns an error. The request port takes one lookup at a time and stays closed until the answer has been given.

Top module: `pgtbl_xlate`

## Requirements
- R1: After reset, both registers read as zero in effect. `req_ready` is high, and `rsp_valid` and `mem_req_valid` are low. Any lookup faults without issuing a memory read.
- R2: The slot fetch address is computed as follows: take the origin register with bit 31 forced to zero, then add the page number times 8. The page number is request address bits 31:12. The sum is kept to 32 bits.
- R3: A lookup is in range only when its page number is strictly less than the extent register shifted right by 3. An out-of-range lookup responds with `rsp_ok`=0 and `rsp_paddr`=0 and makes no memory read.
- R4: When the slot read returns without error, the response has `rsp_ok`=1. `rsp_paddr` is the returned word with bits 11:0 replaced by request address bits 11:0.
- R5: When the slot read returns with `mem_rsp_err`=1, the response has `rsp_ok`=0 and `rsp_paddr`=0.
- R6: `req_ready` is low from the cycle after a lookup is accepted until the cycle after its response. Each accepted lookup produces exactly one single-cycle `rsp_valid` pulse.
- R7: Each in-range lookup issues exactly one memory read. `mem_req_valid` and `mem_req_addr` stay steady until `mem_req_ready` is seen.
- R8: A register write in the same cycle that a lookup is accepted does not affect that lookup. The lookup uses the register values from before that cycle, and the write applies to later lookups.
- R9: `cfg_sel`=0 writes the origin register and `cfg_sel`=1 writes the extent register. A write to one register leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 origin, 1 extent |
| cfg_wdata | input | 32 | Register write value |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted when high with req_valid |
| req_addr | input | 32 | Device-side address to translate |
| mem_req_valid | output | 1 | Table slot read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the table slot |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Frame word of the slot |
| mem_rsp_err | input | 1 | Read failed |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_ok | output | 1 | 1: translated with read/write permission; 0: fault |
| rsp_paddr | output | 32 | Translated address, zero on fault |

## Verification
Two functions can land on the same clock edge: a register write and the acceptance of a lookup. The bench provokes this by raising `cfg_we` together with `req_valid` while `req_ready` is high. It shrinks the extent to zero under an in-range lookup, and it widens a zero extent under another lookup. It then judges each of those lookups against the old extent and the lookup that follows against the new one. The range check is swept across every page number around the extent boundary for several extents and two origins, one of them with bit 31 set. Memory stalls and latencies are varied throughout the sweep.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  localparam int unsigned PGX_AW         = 32;
  localparam int unsigned PGX_PAGE_SHIFT = 12;
  localparam int unsigned PGX_SLOT_SHIFT = 3;

  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_FETCH = 2'd1,
    WS_WAIT  = 2'd2,
    WS_RESP  = 2'd3
  } walk_state_e;

  typedef struct packed {
    logic                  ok;
    logic [PGX_AW-1:0]     paddr;
  } walk_result_t;
endpackage

// File: rtl/pgx_rst_sync.sv
module pgx_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/pgx_cfg_regs.sv
module pgx_cfg_regs #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] origin_q,
  output logic [AW-1:0] extent_q
);
  logic          origin_en, extent_en;
  logic [AW-1:0] origin_d, extent_d;

  always_comb begin
    origin_en = cfg_we && !cfg_sel;
    extent_en = cfg_we &&  cfg_sel;
    origin_d  = cfg_wdata;
    extent_d  = cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      origin_q <= '0;
      extent_q <= '0;
    end else begin
      if (origin_en) origin_q <= origin_d;
      if (extent_en) extent_q <= extent_d;
    end
  end
endmodule

// File: rtl/pgx_index_calc.sv
module pgx_index_calc #(
  parameter int unsigned AW           = 32,
  parameter int unsigned PAGE_SHIFT   = 12,
  parameter int unsigned SLOT_SHIFT   = 3,
  parameter bit          ORIGIN_MSB_OFF = 1'b1
) (
  input  logic [AW-1:0]         laddr,
  input  logic [AW-1:0]         origin,
  input  logic [AW-1:0]         extent,
  output logic [AW-1:0]         slot_addr,
  output logic                  in_range,
  output logic [PAGE_SHIFT-1:0] page_off
);
  localparam int unsigned IDX_W = AW - PAGE_SHIFT;

  logic [IDX_W-1:0] page_idx;
  logic [AW-1:0]    idx_ext;
  logic [AW-1:0]    slot_count;
  logic [AW-1:0]    origin_eff;

  generate
    if (ORIGIN_MSB_OFF) begin : g_msb_off
      assign origin_eff = {1'b0, origin[AW-2:0]};
    end else begin : g_msb_kept
      assign origin_eff = origin;
    end
  endgenerate

  always_comb begin
    page_idx   = laddr[AW-1:PAGE_SHIFT];
    page_off   = laddr[PAGE_SHIFT-1:0];
    idx_ext    = {{PAGE_SHIFT{1'b0}}, page_idx};
    slot_count = extent >> SLOT_SHIFT;
    in_range   = (idx_ext < slot_count);
    slot_addr  = origin_eff + (idx_ext << SLOT_SHIFT);
  end
endmodule

// File: rtl/pgx_walk_ctrl.sv
module pgx_walk_ctrl
  import pgx_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned PAGE_SHIFT = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [AW-1:0]         slot_addr,
  input  logic                  in_range,
  input  logic [PAGE_SHIFT-1:0] page_off,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic [AW-1:0]         mem_req_addr,
  input  logic                  mem_rsp_valid,
  input  logic [AW-1:0]         mem_rsp_data,
  input  logic                  mem_rsp_err,
  output logic                  rsp_valid,
  output walk_result_t          rsp_result
);
  walk_state_e           st_q, st_d;
  logic [AW-1:0]         slot_q, slot_d;
  logic [PAGE_SHIFT-1:0] off_q, off_d;
  walk_result_t          res_q, res_d;
  logic                  cap_en, res_en;

  always_comb begin
    st_d          = st_q;
    slot_d        = slot_q;
    off_d         = off_q;
    res_d         = res_q;
    cap_en        = 1'b0;
    res_en        = 1'b0;
    req_ready     = 1'b0;
    mem_req_valid = 1'b0;
    rsp_valid     = 1'b0;
    unique case (st_q)
      WS_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) begin
          cap_en = 1'b1;
          slot_d = slot_addr;
          off_d  = page_off;
          if (in_range) begin
            st_d = WS_FETCH;
          end else begin
            res_en      = 1'b1;
            res_d.ok    = 1'b0;
            res_d.paddr = '0;
            st_d        = WS_RESP;
          end
        end
      end
      WS_FETCH: begin
        mem_req_valid = 1'b1;
        if (mem_req_ready) st_d = WS_WAIT;
      end
      WS_WAIT: begin
        if (mem_rsp_valid) begin
          res_en = 1'b1;
          if (mem_rsp_err) begin
            res_d.ok    = 1'b0;
            res_d.paddr = '0;
          end else begin
            res_d.ok    = 1'b1;
            res_d.paddr = {mem_rsp_data[AW-1:PAGE_SHIFT], off_q};
          end
          st_d = WS_RESP;
        end
      end
      WS_RESP: begin
        rsp_valid = 1'b1;
        st_d      = WS_IDLE;
      end
      default: st_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WS_IDLE;
      slot_q <= '0;
      off_q  <= '0;
      res_q  <= '0;
    end else begin
      st_q <= st_d;
      if (cap_en) begin
        slot_q <= slot_d;
        off_q  <= off_d;
      end
      if (res_en) res_q <= res_d;
    end
  end

  assign mem_req_addr = slot_q;
  assign rsp_result   = res_q;
endmodule

// File: rtl/pgtbl_xlate.sv
module pgtbl_xlate
  import pgx_pkg::*;
#(
  parameter int unsigned AW         = PGX_AW,
  parameter int unsigned PAGE_SHIFT = PGX_PAGE_SHIFT,
  parameter int unsigned SLOT_SHIFT = PGX_SLOT_SHIFT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [AW-1:0] mem_rsp_data,
  input  logic          mem_rsp_err,
  output logic          rsp_valid,
  output logic          rsp_ok,
  output logic [AW-1:0] rsp_paddr
);
  logic                  rst_n_int;
  logic [AW-1:0]         origin_q, extent_q, slot_addr;
  logic                  in_range;
  logic [PAGE_SHIFT-1:0] page_off;
  walk_result_t          result;

  pgx_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_int)
  );

  pgx_cfg_regs #(.AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .origin_q  (origin_q),
    .extent_q  (extent_q)
  );

  pgx_index_calc #(
    .AW(AW), .PAGE_SHIFT(PAGE_SHIFT), .SLOT_SHIFT(SLOT_SHIFT), .ORIGIN_MSB_OFF(1'b1)
  ) u_idx (
    .laddr     (req_addr),
    .origin    (origin_q),
    .extent    (extent_q),
    .slot_addr (slot_addr),
    .in_range  (in_range),
    .page_off  (page_off)
  );

  pgx_walk_ctrl #(.AW(AW), .PAGE_SHIFT(PAGE_SHIFT)) u_walk (
    .clk           (clk),
    .rst_n         (rst_n_int),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .slot_addr     (slot_addr),
    .in_range      (in_range),
    .page_off      (page_off),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .mem_rsp_err   (mem_rsp_err),
    .rsp_valid     (rsp_valid),
    .rsp_result    (result)
  );

  assign rsp_ok    = result.ok;
  assign rsp_paddr = result.paddr;
endmodule

// File: rtl/pgx_xlate_checker.sv
module pgx_xlate_checker #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          rsp_valid,
  input logic          rsp_ok,
  input logic [AW-1:0] rsp_paddr
);
  logic busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      busy_q <= 1'b0;
    else if (rsp_valid)              busy_q <= 1'b0;
    else if (req_valid && req_ready) busy_q <= 1'b1;
  end

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_reopen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> req_ready);

  p_rsp_owed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> busy_q);

  p_closed_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !req_ready);

  p_read_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_read_owned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy_q);

  p_fault_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ok) |-> (rsp_paddr == '0));
endmodule

bind pgtbl_xlate pgx_xlate_checker #(.AW(AW)) u_pgx_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .rsp_valid     (rsp_valid),
  .rsp_ok        (rsp_ok),
  .rsp_paddr     (rsp_paddr)
);

// File: tb/pgtbl_xlate_bench.sv
module pgtbl_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_sel;
  logic [31:0] cfg_wdata;
  logic        req_valid, req_ready;
  logic [31:0] req_addr;
  logic        mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid, mem_rsp_err;
  logic [31:0] mem_rsp_data;
  logic        rsp_valid, rsp_ok;
  logic [31:0] rsp_paddr;

  int checks = 0;
  int errors = 0;

  // memory model state
  int          reads      = 0;
  logic [31:0] last_raddr = '0;
  int          stall_set  = 0;
  int          lat_set    = 0;
  bit          err_set    = 1'b0;
  int          stall_cnt  = 0;
  int          lat_cnt    = 0;
  bit          pend       = 1'b0;

  always #2 clk = ~clk;

  pgtbl_xlate u_pgtbl_xlate (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_paddr(rsp_paddr)
  );

  function automatic logic [31:0] frame_of(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h3C5A_7E91;
  endfunction

  // memory: decides at each falling edge what the next rising edge sees
  always @(negedge clk) begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_err   = 1'b0;
    if (pend) begin
      if (lat_cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_err   = err_set;
        mem_rsp_data  = frame_of(last_raddr);
        pend          = 1'b0;
      end else lat_cnt--;
    end else if (mem_req_valid) begin
      if (stall_cnt > 0) stall_cnt--;
      else begin
        mem_req_ready = 1'b1;
        last_raddr    = mem_req_addr;
        reads++;
        pend          = 1'b1;
        lat_cnt       = lat_set;
      end
    end
  end

  task automatic check(input bit cond, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input bit sel, input logic [31:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one lookup; optional register write on the accept cycle
  task automatic lookup(input logic [31:0] la, input bit exp_ok, input logic [31:0] exp_slot,
                        input string req, input bit side_we, input bit side_sel,
                        input logic [31:0] side_val);
    int r0, wd, pulses;
    logic [31:0] exp_pa;
    @(negedge clk);
    wd = 0;
    while (!req_ready && wd < 200) begin @(negedge clk); wd++; end
    stall_cnt = stall_set;
    r0 = reads;
    req_valid = 1'b1; req_addr = la;
    if (side_we) begin cfg_we = 1'b1; cfg_sel = side_sel; cfg_wdata = side_val; end
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    check(!req_ready, "R6", "ready after accept", {31'd0, req_ready}, 32'd0);
    wd = 0;
    while (!rsp_valid && wd < 200) begin @(negedge clk); wd++; end
    if (!rsp_valid) begin
      check(1'b0, req, "response timeout", 32'd0, 32'd1);
      return;
    end
    exp_pa = exp_ok ? {frame_of(exp_slot)[31:12], la[11:0]} : 32'd0;
    check(rsp_ok == exp_ok, req, "rsp_ok", {31'd0, rsp_ok}, {31'd0, exp_ok});
    check(rsp_paddr == exp_pa, req, "rsp_paddr", rsp_paddr, exp_pa);
    pulses = 1;
    @(negedge clk);
    if (rsp_valid) pulses++;
    check(pulses == 1, "R6", "pulse length", pulses, 1);
    check(req_ready, "R6", "ready after response", {31'd0, req_ready}, 32'd1);
  endtask

  // lookups that also check read count and slot address
  task automatic lookup_full(input logic [31:0] la, input logic [31:0] origin,
                             input logic [31:0] extent, input string req);
    logic [31:0] idx, slot;
    bit inr;
    int r0;
    idx  = la >> 12;
    inr  = idx < (extent >> 3);
    slot = {1'b0, origin[30:0]} + (idx << 3);
    r0   = reads;
    lookup(la, inr && !err_set, slot, req, 1'b0, 1'b0, 32'd0);
    check((reads - r0) == (inr ? 1 : 0), "R7", "read count", reads - r0, inr ? 1 : 0);
    if (inr) check(last_raddr == slot, "R2", "slot address", last_raddr, slot);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    check(1'b0, "WDOG", "watchdog expired", 32'd0, 32'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] origins [2];
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
    req_valid = 1'b0; req_addr = '0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0; mem_rsp_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check(req_ready == 1'b1, "R1", "req_ready", {31'd0, req_ready}, 32'd1);
    check(rsp_valid == 1'b0, "R1", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check(mem_req_valid == 1'b0, "R1", "mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
    lookup_full(32'h0000_0123, 32'd0, 32'd0, "R1");
    lookup_full(32'hFFFF_FFFF, 32'd0, 32'd0, "R1");

    // R2 R3 R4 R9: sweep page numbers around the extent boundary
    origins[0] = 32'h0001_0000;
    origins[1] = 32'h8002_0008;
    foreach (origins[o]) begin
      cfg_write(1'b0, origins[o]);
      for (int k = 0; k < 5; k++) begin
        for (int r = 0; r < 8; r += 7) begin
          cfg_write(1'b1, 32'(k * 8 + r));
          for (int i = 0; i <= k + 1; i++) begin
            stall_set = (i % 3);
            lat_set   = (i + k) % 4;
            lookup_full((32'(i) << 12) | 32'((i * 37 + r * 5 + o) & 12'hFFF),
                        origins[o], 32'(k * 8 + r), (i < k) ? "R4" : "R3");
          end
        end
      end
    end

    // R9: writing the origin leaves the extent alone
    cfg_write(1'b1, 32'd24);
    cfg_write(1'b0, 32'h0000_4000);
    lookup_full(32'h0000_2ABC, 32'h0000_4000, 32'd24, "R9");
    lookup_full(32'h0000_3ABC, 32'h0000_4000, 32'd24, "R9");

    // R5: read error yields a fault
    stall_set = 1; lat_set = 2; err_set = 1'b1;
    lookup_full(32'h0000_1777, 32'h0000_4000, 32'd24, "R5");
    err_set = 1'b0;
    lookup_full(32'h0000_1777, 32'h0000_4000, 32'd24, "R5");

    // R8: extent write coinciding with acceptance
    stall_set = 0; lat_set = 0;
    cfg_write(1'b1, 32'd64);
    lookup(32'h0000_2010, 1'b1, 32'h0000_4010, "R8", 1'b1, 1'b1, 32'd0);
    lookup_full(32'h0000_2010, 32'h0000_4000, 32'd0, "R8");
    lookup(32'h0000_1020, 1'b0, 32'd0, "R8", 1'b1, 1'b1, 32'd64);
    lookup_full(32'h0000_1020, 32'h0000_4000, 32'd64, "R8");

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule